// File: doc/BRIEF.md
# Dual-Channel High/Low Phase PWM Generator

This block produces two independent pulse-width-modulated outputs. Each output's waveform is set by two separate phase lengths, not by a period and a compare value. The output is driven high for a programmed number of count ticks, then low for a second programmed number, and the pattern repeats. A small register port configures both channels through one shared control word and one count word per channel.

Each channel takes four clock-enable pulse inputs that are shared by both channels and selects one of them. A 7-bit prescaler divides the selected pulses down to count ticks. A channel runs only while both its prescaler gate and its output enable are set. Clearing either bit forces the output low at once and returns the channel to the start of its high phase.

The block has no polarity control. Software inverts a waveform by exchanging the two counts. Counts written while a channel runs are held back until its next high phase begins, so a period in progress is never cut short by an update.

Top module: `duo_phase_pwm`

## Requirements
- R1: Address 1 holds channel 0's count word and address 2 holds channel 1's. In each count word, bits 15:0 are the low-phase count and bits 31:16 are the high-phase count. Both words read back exactly as written. The control word at address 0 reads back with every bit outside 0, 1 and 4..23 forced to zero. Address 3 reads zero. After reset every register reads zero and both outputs are low.
- R2: In the control word, bit 0 is channel 0's output enable and bit 1 is channel 1's. Bit 15 is channel 0's prescaler gate and bit 23 is channel 1's. A channel's output stays low unless both its enable bit and its gate bit are 1.
- R3: Channel 0's prescaler value is in bits 14:8 and channel 1's is in bits 22:16. A count tick happens once every (value + 1) pulses of the selected source.
- R4: Channel 0's source select is in bits 5:4 and channel 1's is in bits 7:6. A select value n picks src_tick[n]. A channel whose selected source never pulses holds its output unchanged.
- R5: When a channel starts running, its output goes high in the first cycle after the control write. The output then stays high for the high count of ticks, goes low for the low count of ticks, and repeats.
- R6: A high or low count of zero is treated as one tick. A zero low count therefore gives one low tick per period, and two zero counts toggle the output on every tick.
- R7: When a channel's enable is cleared, its output is low from the first cycle after the write, even in the middle of a period. Enabling the channel again starts a fresh high phase.
- R8: A count word written while its channel runs does not change the period in progress. The new counts apply from the next high phase.
- R9: The two channels run independently of each other, each with its own counts, prescaler and source.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 2 | Register read address |
| rd_data | output | 32 | Register read data for rd_addr (combinational) |
| src_tick | input | 4 | Four clock-enable pulse sources shared by both channels |
| pwm_out | output | 2 | PWM outputs; bit 0 is channel 0 |

## Verification
The assertions assume that reset is asserted at time zero across at least one clock edge. They also assume that src_tick, wr_en, wr_addr and wr_data are known and change only between edges, because the stall and start-of-run properties compare the samples taken at successive edges. The bench drives every input on falling edges. It holds the four source pulses at fixed levels: two sources always active and two always idle. Each run's expected waveform is therefore set only by the counts, the prescaler and the control writes, all of which the bench issues at known cycles.

// File: rtl/duo_pwm_pkg.sv
package duo_pwm_pkg;

    localparam int NCH    = 2;
    localparam int NSRC   = 4;
    localparam int SEL_W  = 2;
    localparam int DIV_W  = 7;
    localparam int ADDR_W = 2;
    localparam int CTRL_W = 32;

    localparam logic [ADDR_W-1:0] ADR_CTRL = 2'd0;

    function automatic int en_pos(input int ch);
        return ch;
    endfunction

    function automatic int sel_pos(input int ch);
        return 4 + SEL_W * ch;
    endfunction

    function automatic int div_pos(input int ch);
        return 8 + 8 * ch;
    endfunction

    function automatic int gate_pos(input int ch);
        return div_pos(ch) + DIV_W;
    endfunction

    // Bits of the control word that carry a function; the rest read zero.
    function automatic logic [CTRL_W-1:0] ctrl_mask();
        logic [CTRL_W-1:0] m;
        m = '0;
        for (int ch = 0; ch < NCH; ch++) begin
            m[en_pos(ch)]   = 1'b1;
            m[gate_pos(ch)] = 1'b1;
            for (int b = 0; b < SEL_W; b++) m[sel_pos(ch) + b] = 1'b1;
            for (int b = 0; b < DIV_W; b++) m[div_pos(ch) + b] = 1'b1;
        end
        return m;
    endfunction

    typedef enum logic {
        PH_HIGH = 1'b0,
        PH_LOW  = 1'b1
    } phase_e;

endpackage

// File: rtl/duo_pwm_regs.sv
module duo_pwm_regs
    import duo_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [ADDR_W-1:0]             wr_addr,
    input  logic [DATA_W-1:0]             wr_data,
    input  logic [ADDR_W-1:0]             rd_addr,
    output logic [DATA_W-1:0]             rd_data,
    output logic [DATA_W-1:0]             ctrl_q,
    output logic [NCH-1:0][DATA_W-1:0]    count_q
);

    localparam logic [DATA_W-1:0] MASK = DATA_W'(ctrl_mask());

    typedef struct packed {
        logic [DATA_W-1:0]          ctrl;
        logic [NCH-1:0][DATA_W-1:0] cnt;
    } regs_t;

    regs_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (wr_en) begin
            if (wr_addr == ADR_CTRL) r_d.ctrl = wr_data & MASK;
            for (int ch = 0; ch < NCH; ch++) begin
                if (wr_addr == ADDR_W'(ch + 1)) r_d.cnt[ch] = wr_data;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    always_comb begin
        rd_data = '0;
        if (rd_addr == ADR_CTRL) rd_data = r_q.ctrl;
        for (int ch = 0; ch < NCH; ch++) begin
            if (rd_addr == ADDR_W'(ch + 1)) rd_data = r_q.cnt[ch];
        end
    end

    assign ctrl_q  = r_q.ctrl;
    assign count_q = r_q.cnt;

endmodule

// File: rtl/duo_pwm_presc.sv
module duo_pwm_presc
    import duo_pwm_pkg::*;
(
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [NSRC-1:0]  src_tick,
    input  logic [SEL_W-1:0] sel,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] pc_d, pc_q;
    logic             src;

    assign src = src_tick[sel];

    always_comb begin
        pc_d = pc_q;
        tick = 1'b0;
        if (!run) begin
            pc_d = '0;
        end else if (src) begin
            if (pc_q >= div) begin
                pc_d = '0;
                tick = 1'b1;
            end else begin
                pc_d = pc_q + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pc_q <= '0;
        else        pc_q <= pc_d;
    end

endmodule

// File: rtl/duo_pwm_phase.sv
module duo_pwm_phase
    import duo_pwm_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic             tick,
    input  logic [CNT_W-1:0] hi_cnt,
    input  logic [CNT_W-1:0] lo_cnt,
    output logic             out
);

    typedef struct packed {
        phase_e           ph;
        logic [CNT_W-1:0] cnt;
        logic [CNT_W-1:0] hi;
        logic [CNT_W-1:0] lo;
    } state_t;

    state_t s_d, s_q;
    logic [CNT_W-1:0] limit;
    logic             last;

    assign limit = (s_q.ph == PH_HIGH) ? s_q.hi : s_q.lo;
    // A zero limit behaves as one tick.
    assign last  = ((CNT_W + 1)'(s_q.cnt) + 1'b1) >= {1'b0, limit};

    always_comb begin
        s_d = s_q;
        if (!run) begin
            s_d.ph  = PH_HIGH;
            s_d.cnt = '0;
            s_d.hi  = hi_cnt;
            s_d.lo  = lo_cnt;
        end else if (tick) begin
            if (last) begin
                s_d.cnt = '0;
                if (s_q.ph == PH_HIGH) begin
                    s_d.ph = PH_LOW;
                end else begin
                    s_d.ph = PH_HIGH;
                    s_d.hi = hi_cnt;
                    s_d.lo = lo_cnt;
                end
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{ph: PH_HIGH, cnt: '0, hi: '0, lo: '0};
        else        s_q <= s_d;
    end

    assign out = run && (s_q.ph == PH_HIGH);

endmodule

// File: rtl/duo_phase_pwm.sv
module duo_phase_pwm
    import duo_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DATA_W = 2 * CNT_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [NSRC-1:0]   src_tick,
    output logic [NCH-1:0]    pwm_out
);

    logic [DATA_W-1:0]          ctrl_q;
    logic [NCH-1:0][DATA_W-1:0] count_q;

    duo_pwm_regs #(.CNT_W(CNT_W)) u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_addr (wr_addr),
        .wr_data (wr_data),
        .rd_addr (rd_addr),
        .rd_data (rd_data),
        .ctrl_q  (ctrl_q),
        .count_q (count_q)
    );

    for (genvar g = 0; g < NCH; g++) begin : g_ch
        localparam int EP = en_pos(g);
        localparam int GP = gate_pos(g);
        localparam int SP = sel_pos(g);
        localparam int DP = div_pos(g);

        logic run;
        logic tick;

        assign run = ctrl_q[EP] & ctrl_q[GP];

        duo_pwm_presc u_presc (
            .clk      (clk),
            .rst_n    (rst_n),
            .run      (run),
            .src_tick (src_tick),
            .sel      (ctrl_q[SP +: SEL_W]),
            .div      (ctrl_q[DP +: DIV_W]),
            .tick     (tick)
        );

        duo_pwm_phase #(.CNT_W(CNT_W)) u_phase (
            .clk    (clk),
            .rst_n  (rst_n),
            .run    (run),
            .tick   (tick),
            .hi_cnt (count_q[g][DATA_W-1:CNT_W]),
            .lo_cnt (count_q[g][CNT_W-1:0]),
            .out    (pwm_out[g])
        );
    end

endmodule

// File: rtl/duo_phase_pwm_chk.sv
module duo_phase_pwm_chk
    import duo_pwm_pkg::*;
#(
    parameter int CNT_W = 16,
    localparam int DATA_W = 2 * CNT_W
) (
    input logic                       clk,
    input logic                       rst_n,
    input logic                       wr_en,
    input logic [ADDR_W-1:0]          wr_addr,
    input logic [DATA_W-1:0]          wr_data,
    input logic [NSRC-1:0]            src_tick,
    input logic [NCH-1:0]             pwm_out,
    input logic [DATA_W-1:0]          ctrl_q,
    input logic [NCH-1:0][DATA_W-1:0] count_q
);

    for (genvar g = 0; g < NCH; g++) begin : g_chk
        logic             run_c;
        logic [SEL_W-1:0] sel_c;
        logic             src_c;

        assign run_c = ctrl_q[en_pos(g)] & ctrl_q[gate_pos(g)];
        assign sel_c = ctrl_q[sel_pos(g) +: SEL_W];
        assign src_c = src_tick[sel_c];

        // R1: a count word write is held as written
        assert_count_write_R1: assert property (@(posedge clk) disable iff (!rst_n)
            wr_en && (wr_addr == ADDR_W'(g + 1)) |=> count_q[g] == $past(wr_data));

        // R5: a run always opens with the high phase
        assert_start_high_R5: assert property (@(posedge clk) disable iff (!rst_n)
            $rose(run_c) |-> pwm_out[g]);

        // R4: no source pulse means the output does not move
        assert_stall_no_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
            run_c && !src_c ##1 run_c |-> $stable(pwm_out[g]));

        // R7: the cycle the channel stops, the output is already low
        assert_stop_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
            $fell(ctrl_q[en_pos(g)]) |-> !pwm_out[g]);
    end

endmodule

bind duo_phase_pwm duo_phase_pwm_chk #(.CNT_W(CNT_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (wr_addr),
    .wr_data  (wr_data),
    .src_tick (src_tick),
    .pwm_out  (pwm_out),
    .ctrl_q   (ctrl_q),
    .count_q  (count_q)
);

// File: tb/sim_duo_phase_pwm.sv
module sim_duo_phase_pwm;

    localparam int CLK_PERIOD = 10;
    localparam int MAXP = 300;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [1:0]  wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic [1:0]  rd_addr = '0;
    logic [31:0] rd_data;
    logic [3:0]  src_tick = 4'b1001;
    logic [1:0]  pwm_out;

    int total = 0;
    int fails = 0;
    bit done = 1'b0;
    logic [1:0] exp_q [0:MAXP-1];

    always #(CLK_PERIOD / 2) clk = ~clk;

    duo_phase_pwm u0 (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_en),
        .wr_addr  (wr_addr),
        .wr_data  (wr_data),
        .rd_addr  (rd_addr),
        .rd_data  (rd_data),
        .src_tick (src_tick),
        .pwm_out  (pwm_out)
    );

    function automatic logic [31:0] ctl(input bit en0, input bit g0, input int s0, input int d0,
                                        input bit en1, input bit g1, input int s1, input int d1);
        logic [31:0] v;
        v = '0;
        v[0] = en0;  v[1] = en1;
        v[5:4] = 2'(s0);  v[7:6] = 2'(s1);
        v[14:8] = 7'(d0); v[15] = g0;
        v[22:16] = 7'(d1); v[23] = g1;
        return v;
    endfunction

    function automatic logic [31:0] cw(input int hi, input int lo);
        return {16'(hi), 16'(lo)};
    endfunction

    function automatic bit wave(input int p, input int hi, input int lo, input int d);
        int h, l;
        h = (hi == 0) ? 1 : hi;
        l = (lo == 0) ? 1 : lo;
        return ((p / (d + 1)) % (h + l)) < h;
    endfunction

    task automatic check(input string req, input bit ok, input logic [31:0] act, input logic [31:0] exp);
        total++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd_check(input string req, input logic [1:0] a, input logic [31:0] exp);
        rd_addr = a;
        #1;
        check(req, rd_data === exp, rd_data, exp);
    endtask

    task automatic clear_exp();
        for (int p = 0; p < MAXP; p++) exp_q[p] = 2'b00;
    endtask

    task automatic fill(input int ch, input int from, input int to, input int hi, input int lo,
                        input int d, input int off);
        for (int p = from; p < to; p++) exp_q[p][ch] = wave(p - off, hi, lo, d);
    endtask

    task automatic fill_const(input int ch, input int from, input int to, input bit v);
        for (int p = from; p < to; p++) exp_q[p][ch] = v;
    endtask

    // Compare both outputs for n cycles; optionally issue one write at step wp.
    task automatic watch(input string req, input int n, input int wp, input logic [1:0] wa,
                         input logic [31:0] wd);
        bit ok0, ok1;
        int bad0, bad1;
        ok0 = 1'b1; ok1 = 1'b1; bad0 = 0; bad1 = 0;
        for (int p = 0; p < n; p++) begin
            if (ok0 && pwm_out[0] !== exp_q[p][0]) begin ok0 = 1'b0; bad0 = p; end
            if (ok1 && pwm_out[1] !== exp_q[p][1]) begin ok1 = 1'b0; bad1 = p; end
            wr_en = (p == wp); wr_addr = wa; wr_data = wd;
            @(negedge clk);
        end
        wr_en = 1'b0;
        if (!ok0) $display("FAIL detail %s ch0 step %0d", req, bad0);
        if (!ok1) $display("FAIL detail %s ch1 step %0d", req, bad1);
        check({req, " ch0"}, ok0, 32'(!exp_q[bad0][0]), 32'(exp_q[bad0][0]));
        check({req, " ch1"}, ok1, 32'(!exp_q[bad1][1]), 32'(exp_q[bad1][1]));
    endtask

    task automatic stop_all();
        wr(2'd0, 32'h0);
        @(negedge clk);
    endtask

    task automatic t_reset();
        rd_check("R1 reset ctrl", 2'd0, 32'h0);
        rd_check("R1 reset cnt0", 2'd1, 32'h0);
        rd_check("R1 reset cnt1", 2'd2, 32'h0);
        check("R1 reset outputs", pwm_out === 2'b00, 32'(pwm_out), 32'h0);
    endtask

    task automatic t_regs();
        wr(2'd1, 32'hABCD_1234);
        wr(2'd2, 32'h0005_0007);
        wr(2'd0, 32'hFFFF_FFFF);
        rd_check("R1 cnt0 readback", 2'd1, 32'hABCD_1234);
        rd_check("R1 cnt1 readback", 2'd2, 32'h0005_0007);
        rd_check("R1 ctrl readback", 2'd0, 32'h00FF_FFF3);
        rd_check("R1 unused address", 2'd3, 32'h0);
        stop_all();
    endtask

    task automatic t_basic();
        wr(2'd1, cw(3, 2));
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        clear_exp();
        fill(0, 0, 40, 3, 2, 0, 0);
        watch("R5 basic", 40, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_presc();
        wr(2'd1, cw(2, 1));
        wr(2'd2, cw(1, 3));
        wr(2'd0, ctl(1, 1, 0, 2, 1, 1, 3, 1));
        clear_exp();
        fill(0, 0, 60, 2, 1, 2, 0);
        fill(1, 0, 60, 1, 3, 1, 0);
        watch("R3 R9 prescale", 60, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_gate();
        wr(2'd1, cw(2, 2));
        wr(2'd2, cw(2, 2));
        wr(2'd0, ctl(1, 0, 0, 0, 0, 1, 0, 0));
        clear_exp();
        watch("R2 gate/enable", 20, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_src();
        wr(2'd1, cw(2, 2));
        wr(2'd2, cw(2, 2));
        wr(2'd0, ctl(1, 1, 1, 0, 1, 1, 3, 0));
        clear_exp();
        fill_const(0, 0, 30, 1'b1);
        fill(1, 0, 30, 2, 2, 0, 0);
        watch("R4 source select", 30, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_zero();
        wr(2'd1, cw(5, 0));
        wr(2'd2, cw(0, 3));
        wr(2'd0, ctl(1, 1, 0, 0, 1, 1, 0, 0));
        clear_exp();
        fill(0, 0, 30, 5, 0, 0, 0);
        fill(1, 0, 30, 0, 3, 0, 0);
        watch("R6 zero count", 30, -1, 2'd0, 32'h0);
        stop_all();
        wr(2'd1, cw(0, 0));
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        clear_exp();
        fill(0, 0, 20, 0, 0, 0, 0);
        watch("R6 both zero", 20, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_stop();
        wr(2'd1, cw(4, 4));
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        clear_exp();
        fill(0, 0, 3, 4, 4, 0, 0);
        watch("R7 stop mid-period", 12, 2, 2'd0, 32'h0);
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        clear_exp();
        fill(0, 0, 20, 4, 4, 0, 0);
        watch("R7 restart", 20, -1, 2'd0, 32'h0);
        stop_all();
    endtask

    task automatic t_update();
        wr(2'd1, cw(3, 2));
        wr(2'd0, ctl(1, 1, 0, 0, 0, 0, 0, 0));
        clear_exp();
        fill(0, 0, 5, 3, 2, 0, 0);
        fill(0, 5, 25, 1, 1, 0, 5);
        watch("R8 deferred update", 25, 0, 2'd1, cw(1, 1));
        stop_all();
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_regs();
        t_basic();
        t_presc();
        t_gate();
        t_src();
        t_zero();
        t_stop();
        t_update();
        if (!done) begin
            done = 1'b1;
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            fails++;
            $display("FAIL watchdog (all requirements): actual timeout expected completion");
            $display("%0d/%0d checks passed", total - fails, total);
            $finish;
        end
    end

endmodule